// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a chain of storage stages that either captures a whole parallel word at once or moves its contents one stage along, taking a new bit from a serial input. Only the last stage reaches a pin, so the block turns a word into a bit stream that comes out most significant bit first. If the serial output of one instance drives the serial input of the next, the instances form one longer register.

Two active-low controls choose what happens at each rising clock edge. The clock enable gates every synchronous action. With the clock enabled, the load control picks between a parallel capture and a serial shift. An active-low clear empties every stage at once, whether or not the clock is running. The clock enable acts as a synchronous enable on the flip-flops, so the clock net itself is never gated.

Top module: `piso_shift_reg`

## Requirements
- R1: Driving `rst_n` low clears every stage to 0 at once, without waiting for a clock edge, so `ser_out` reads 0 while the clear is held.
- R2: At a rising edge with `clk_en_n`=0 and `load_n`=0, stage i takes `par_in[i]` for every i in one step. After that edge `ser_out` equals `par_in[WIDTH-1]`.
- R3: At a rising edge with `clk_en_n`=0 and `load_n`=1, stage 0 takes `ser_in` and each stage i>0 takes the old value of stage i-1. After that edge `ser_out` equals the old value of stage WIDTH-2.
- R4: After a parallel load followed by WIDTH-1 shifts, `ser_out` has shown the loaded word in order from `par_in[WIDTH-1]` down to `par_in[0]`, one bit per edge.
- R5: At a rising edge with `clk_en_n`=1, every stage keeps its value, whatever `load_n`, `ser_in` and `par_in` are.
- R6: The clear overrides clock activity. While `rst_n` is low, no load or shift takes place, and the register is still empty on the first edge after release.
- R7: When two instances are chained (`ser_out` of the first drives `ser_in` of the second) and loaded with words A and B, the second instance's `ser_out` shows B from its top bit down to bit 0, then A from its top bit down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous actions happen on the rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| clk_en_n | input | 1 | Clock enable, active low; 1 freezes all stages |
| load_n | input | 1 | 0 selects parallel capture, 1 selects serial shift |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel word; bit i goes to stage i |
| ser_out | output | 1 | Value of the last stage |

## Verification
The hardest case to reach from the ports is a clear that arrives in the middle of a serial stream. The bench loads a word, shifts part of it out, and then pulls `rst_n` low between two clock edges. It checks `ser_out` before the next edge comes. It then keeps clocking with load and shift requests while the clear is held, to show that the register stays empty. A chain of two instances, compared against a sixteen-bit reference model on every cycle, shows that bits pass from one instance to the next in order.

// File: rtl/piso_pkg.sv
package piso_pkg;
   typedef enum logic [1:0] {
      MODE_HOLD  = 2'd0,
      MODE_LOAD  = 2'd1,
      MODE_SHIFT = 2'd2
   } piso_mode_e;
endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
   import piso_pkg::*;
(
   input  logic       clk_en_n,
   input  logic       load_n,
   output piso_mode_e mode
);
   always_comb begin
      if (clk_en_n)    mode = MODE_HOLD;
      else if (load_n) mode = MODE_SHIFT;
      else             mode = MODE_LOAD;
   end
endmodule

// File: rtl/piso_stage.sv
module piso_stage
   import piso_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  piso_mode_e mode,
   input  logic       par_bit,
   input  logic       prev_bit,
   output logic       q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else begin
         case (mode)
            MODE_LOAD:  q <= par_bit;
            MODE_SHIFT: q <= prev_bit;
            default:    q <= q;
         endcase
      end
   end
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
   import piso_pkg::*;
#(
   parameter int WIDTH = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en_n,
   input  logic             load_n,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] par_in,
   output logic             ser_out
);
   localparam int LAST = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("piso_shift_reg: WIDTH must be at least 2");
      end
   endgenerate

   piso_mode_e       mode;
   logic [WIDTH-1:0] stage_q;

   piso_ctrl u_ctrl (
      .clk_en_n (clk_en_n),
      .load_n   (load_n),
      .mode     (mode)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         logic prev;
         if (i == 0) begin : g_head
            assign prev = ser_in;
         end else begin : g_body
            assign prev = stage_q[i-1];
         end
         piso_stage u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode),
            .par_bit  (par_in[i]),
            .prev_bit (prev),
            .q        (stage_q[i])
         );
      end
   endgenerate

   assign ser_out = stage_q[LAST];
endmodule

// File: rtl/piso_shift_reg_chk.sv
module piso_shift_reg_chk #(
   parameter int WIDTH = 8
)(
   input logic             clk,
   input logic             rst_n,
   input logic             clk_en_n,
   input logic             load_n,
   input logic             ser_in,
   input logic [WIDTH-1:0] par_in,
   input logic             ser_out,
   input logic [WIDTH-1:0] stage_q
);
   always @(posedge clk) begin
      if (rst_n === 1'b0) begin
         AST_CLEAR_HELD: assert (stage_q == '0 && ser_out == 1'b0); // R1
      end
   end

   AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !load_n) |=> stage_q == $past(par_in)); // R2

   AST_LOAD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !load_n) |=> ser_out == $past(par_in[WIDTH-1])); // R2

   AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && load_n) |=> stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)}); // R3

   AST_HOLD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(stage_q)); // R5

   AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(ser_out)); // R5
endmodule

bind piso_shift_reg piso_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clk_en_n (clk_en_n),
   .load_n   (load_n),
   .ser_in   (ser_in),
   .par_in   (par_in),
   .ser_out  (ser_out),
   .stage_q  (stage_q)
);

// File: tb/tb_piso_shift_reg.sv
module tb_piso_shift_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_en_n = 1'b1;
   logic       load_n = 1'b1;
   logic       ser_in = 1'b0;
   logic [7:0] pa = '0;
   logic [7:0] pb = '0;
   logic       out_a, out_b;
   int         n_tests = 0;
   int         n_fail = 0;
   bit         done = 0;
   string      phase = "R1";
   logic [15:0] model;

   always #4 clk = ~clk;

   piso_shift_reg #(.WIDTH(8)) dut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
      .ser_in(ser_in), .par_in(pa), .ser_out(out_a));

   piso_shift_reg #(.WIDTH(8)) dut2 (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
      .ser_in(out_a), .par_in(pb), .ser_out(out_b));

   // Reference: 16-bit chain, bits 7:0 first instance, 15:8 second
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model <= '0;
      else if (!clk_en_n) begin
         if (!load_n) model <= {pb, pa};
         else         model <= {model[14:0], ser_in};
      end
   end

   task automatic chk(string req, logic act, logic exp, string what);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk(phase, out_a, model[7], "model first");
         chk(phase, out_b, model[15], "model second");
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   initial begin
      #600000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk); #1;
      chk("R1", out_a, 1'b0, "reset state");
      rst_n = 1'b1;
      tick();

      // R2 / R4: load then shift out
      phase = "R4";
      pa = 8'hB2; pb = 8'h00; clk_en_n = 1'b0; load_n = 1'b0;
      tick();
      chk("R2", out_a, pa[7], "load msb");
      load_n = 1'b1; ser_in = 1'b0;
      for (int k = 1; k < 8; k++) begin
         tick();
         chk("R4", out_a, pa[7-k], "shift order");
      end

      // R3: serial bits entering and emerging
      phase = "R3";
      for (int k = 0; k < 10; k++) begin
         ser_in = (k % 3 == 0);
         tick();
      end

      // R5: hold with stirring inputs
      phase = "R5";
      pa = 8'h5A; load_n = 1'b0; tick();
      clk_en_n = 1'b1;
      for (int k = 0; k < 6; k++) begin
         load_n = k[0]; ser_in = ~k[1]; pa = 8'h11 * k[7:0]; pb = ~pa;
         tick();
         chk("R5", out_a, 1'b0, "hold first");
      end
      clk_en_n = 1'b0; load_n = 1'b1; ser_in = 1'b1;
      tick();
      chk("R5", out_a, 1'b1, "resume after hold");

      // R1 / R6: clear mid-stream
      phase = "R6";
      pa = 8'hFF; pb = 8'hFF; load_n = 1'b0; tick();
      load_n = 1'b1; tick(); tick();
      #1 rst_n = 1'b0; #1;
      chk("R1", out_a, 1'b0, "async clear first");
      chk("R1", out_b, 1'b0, "async clear second");
      for (int k = 0; k < 4; k++) begin
         load_n = k[0]; ser_in = 1'b1;
         tick();
         chk("R6", out_a, 1'b0, "clear held");
      end
      rst_n = 1'b1; load_n = 1'b1; ser_in = 1'b0;
      tick();
      chk("R6", out_a, 1'b0, "after release");

      // R7: cascade
      phase = "R7";
      pa = 8'hC3; pb = 8'h6D; load_n = 1'b0;
      tick();
      chk("R7", out_b, pb[7], "cascade first bit");
      load_n = 1'b1; ser_in = 1'b0;
      for (int k = 1; k < 16; k++) begin
         tick();
         if (k < 8) chk("R7", out_b, pb[7-k], "cascade upper word");
         else       chk("R7", out_b, pa[15-k], "cascade lower word");
      end

      phase = "R3";
      for (int k = 0; k < 20; k++) begin
         ser_in = k[0] ^ k[2]; load_n = (k != 9); clk_en_n = (k == 5);
         pa = 8'h3C; pb = 8'h81;
         tick();
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule